// File: doc/BRIEF.md
# Correlation-Guided Test Pattern Generator

This block searches for a test vector that detects a single target fault. It sends N-bit candidate vectors to an external fault-detection oracle, and the oracle answers each one with a hit or a miss. The first three candidates for a fault are pseudo-random. From then on the block uses what it has learned from the misses. For each input it counts the failed vectors in which that input was 1. For each pair of inputs it counts the failed vectors in which both were 1. From these counts it chooses a pivot input. It then builds the next candidate by taking the pivot's conditional statistics and inverting them, which steers the search away from patterns that have already failed.

When the oracle reports a hit, the block keeps the winning vector and pulses a found flag for one cycle. It then clears all learned statistics and the pivot history, and starts on the next fault straight away with fresh random vectors. All probabilities are held as integer counts. Every comparison is done by scaling one side by two, so the block needs no divider.

Top module: `corr_tpg`

## Requirements
- R1: During reset, `vec_valid_o` and `found_o` are 0 and `found_vec_o` is 0. The random source is a 16-bit register loaded from `seed_i` at reset; a seed of zero is replaced by 16'hACE1. The first vector offered after reset is the low N bits of that loaded value.
- R2: While fewer than three misses have been recorded for the current fault, each vector is the low N bits of the random register, and the register then steps once. The step is a left shift whose new bit 0 is bit15 ^ bit13 ^ bit12 ^ bit10.
- R3: Each miss adds 1 to the total count. For every input i that is 1 in the missed vector, it adds 1 to ones[i]. For every pair (i,j) that are both 1, it adds 1 to joint[i][j].
- R4: Once three or more misses exist, the pivot is the input with the smallest ones[] count among inputs not yet used as pivot for this fault. Ties go to the lowest index. The chosen pivot is then marked as used.
- R5: If every input is already marked as used, all marks are cleared before the pivot is chosen, so the new pivot becomes the only marked input.
- R6: In a learned vector, the pivot bit is 1 exactly when 2*ones[p] <= total. Every other bit j is 1 exactly when 2*joint[j][p] <= ones[p]. This means every non-pivot bit is 1 when ones[p] is 0.
- R7: `vec_o` stays stable while `vec_valid_o` is high and `vec_ready_i` is low. Once a vector is accepted, only one verdict is expected. A `verdict_valid_i` pulse that arrives before acceptance is ignored.
- R8: A verdict with `verdict_hit_i`=1 pulses `found_o` for exactly one cycle, on the next cycle. On that cycle `found_vec_o` holds the accepted vector. All counts and pivot marks are cleared, so the next three vectors are random again.
- R9: Every count saturates at 2^CW-1 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_i | input | 16 | Random seed, loaded during reset |
| vec_valid_o | output | 1 | Candidate vector is offered |
| vec_ready_i | input | 1 | Oracle accepts the offered vector |
| vec_o | output | N | Candidate test vector |
| verdict_valid_i | input | 1 | One-cycle verdict strobe |
| verdict_hit_i | input | 1 | Verdict: 1 means the vector detects the fault |
| found_o | output | 1 | One-cycle pulse when a test is found |
| found_vec_o | output | N | Last vector that detected a fault |

## Verification
Two events can land in the same cycle. First, a pivot selection can happen in the very cycle the pivot history runs out; the mask must then be cleared and the new pivot marked in that one cycle. The bench provokes this with long runs in which every vector misses, which forces the search through every input as pivot more than once. Second, a detection can arrive just as learned statistics are about to be used; the clearing must win, so the very next vector is random again. The bench judges both by comparing every offered vector with an arithmetic model. That model recomputes counts, ratios, pivot and history from the requirements, under backpressure and with stray verdict pulses mixed in.

// File: rtl/corr_tpg.sv
module corr_tpg #(
  parameter int N  = 5,
  parameter int CW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [15:0]  seed_i,
  output logic         vec_valid_o,
  input  logic         vec_ready_i,
  output logic [N-1:0] vec_o,
  input  logic         verdict_valid_i,
  input  logic         verdict_hit_i,
  output logic         found_o,
  output logic [N-1:0] found_vec_o
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam int RAND_RUNS = 3;

  typedef enum logic [1:0] {S_GEN, S_ISSUE, S_WAIT} st_t;
  st_t state;

  logic [CW-1:0] cnt [N][N];
  logic [CW-1:0] total;
  logic [N-1:0]  hist, hist_eff, learn_vec, vec_r, found_vec_r;
  logic [15:0]   lfsr, lfsr_nx;
  logic [PW-1:0] piv;
  logic          found_r, use_rand;

  assign use_rand    = total < CW'(RAND_RUNS);
  assign lfsr_nx     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign hist_eff    = (&hist) ? '0 : hist;
  assign vec_valid_o = (state == S_ISSUE);
  assign vec_o       = vec_r;
  assign found_o     = found_r;
  assign found_vec_o = found_vec_r;

  always_comb begin
    logic          have;
    logic [CW-1:0] best;
    have = 1'b0;
    best = CMAX;
    piv  = '0;
    for (int i = 0; i < N; i++) begin
      if (!hist_eff[i] && (!have || cnt[i][i] < best)) begin
        have = 1'b1;
        best = cnt[i][i];
        piv  = PW'(i);
      end
    end
  end

  always_comb begin
    for (int j = 0; j < N; j++) begin
      if (PW'(j) == piv) learn_vec[j] = {cnt[piv][piv], 1'b0} <= {1'b0, total};
      else               learn_vec[j] = {cnt[j][piv], 1'b0} <= {1'b0, cnt[piv][piv]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_GEN;
      lfsr        <= (seed_i == 16'h0) ? 16'hACE1 : seed_i;
      total       <= '0;
      hist        <= '0;
      vec_r       <= '0;
      found_r     <= 1'b0;
      found_vec_r <= '0;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) cnt[i][j] <= '0;
    end else begin
      found_r <= 1'b0;
      case (state)
        S_GEN: begin
          if (use_rand) begin
            vec_r <= lfsr[N-1:0];
            lfsr  <= lfsr_nx;
          end else begin
            vec_r <= learn_vec;
            hist  <= hist_eff | (N'(1) << piv);
          end
          state <= S_ISSUE;
        end
        S_ISSUE: if (vec_ready_i) state <= S_WAIT;
        S_WAIT: if (verdict_valid_i) begin
          state <= S_GEN;
          if (verdict_hit_i) begin
            found_r     <= 1'b1;
            found_vec_r <= vec_r;
            total       <= '0;
            hist        <= '0;
            for (int i = 0; i < N; i++)
              for (int j = 0; j < N; j++) cnt[i][j] <= '0;
          end else begin
            if (total != CMAX) total <= total + 1'b1;
            for (int i = 0; i < N; i++)
              for (int j = 0; j < N; j++)
                if (vec_r[i] && vec_r[j] && cnt[i][j] != CMAX) cnt[i][j] <= cnt[i][j] + 1'b1;
          end
        end
        default: state <= S_GEN;
      endcase
    end
  end

  a_r7_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && !vec_ready_i) |=> (vec_valid_o && $stable(vec_o)));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |=> !found_o);

  a_r8_cleared_on_find: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> (total == '0 && hist == '0 && found_vec_o == $past(vec_r)));

  a_r9_total_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (total == CMAX && !(state == S_WAIT && verdict_valid_i && verdict_hit_i)) |=> total == CMAX);

  a_r9_ones_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[0][0] == CMAX && !found_o && !(state == S_WAIT && verdict_valid_i && verdict_hit_i))
      |=> cnt[0][0] == CMAX);

  a_r2_rand_steps_lfsr: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_GEN && use_rand) |=> (vec_r == $past(lfsr[N-1:0])));
endmodule

// File: tb/corr_tpg_tb.sv
module corr_tpg_tb;
  localparam int NB = 5;
  localparam int MX = 255;

  logic clk = 0, rst_n = 0;
  logic [15:0] seed = 16'h0;
  logic vec_ready = 0, verdict_valid = 0, verdict_hit = 0;
  logic vec_valid, found;
  logic [NB-1:0] vec, found_vec;

  always #2.5 clk = ~clk;

  corr_tpg #(.N(NB), .CW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .seed_i(seed),
    .vec_valid_o(vec_valid), .vec_ready_i(vec_ready), .vec_o(vec),
    .verdict_valid_i(verdict_valid), .verdict_hit_i(verdict_hit),
    .found_o(found), .found_vec_o(found_vec));

  int errors = 0, checks = 0;
  int mc[NB][NB];
  int mt;
  logic [15:0] ml;
  logic [NB-1:0] mh;
  string tag;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NB; i++) for (int j = 0; j < NB; j++) mc[i][j] = 0;
    mt = 0; mh = '0;
  endtask

  // expected next vector from counts (R2 random phase, R4 pivot, R5 wrap, R6 bits)
  task automatic model_gen(output logic [NB-1:0] v);
    logic [NB-1:0] he;
    int p;
    if (mt < 3) begin
      v = ml[NB-1:0];
      ml = {ml[14:0], ml[15] ^ ml[13] ^ ml[12] ^ ml[10]};
      tag = "R2";
    end else begin
      he = (mh == '1) ? '0 : mh;
      tag = (mh == '1) ? "R5" : ((mt == MX) ? "R9" : "R6");
      p = -1;
      for (int i = 0; i < NB; i++)
        if (!he[i] && (p < 0 || mc[i][i] < mc[p][p])) p = i;
      for (int j = 0; j < NB; j++)
        v[j] = (j == p) ? (2 * mc[p][p] <= mt) : (2 * mc[j][p] <= mc[p][p]);
      mh = he | (NB'(1) << p);
    end
  endtask

  // R3: miss updates per-input, pairwise and total counts, saturating (R9)
  task automatic model_miss(input logic [NB-1:0] v);
    for (int i = 0; i < NB; i++)
      for (int j = 0; j < NB; j++)
        if (v[i] && v[j] && mc[i][j] < MX) mc[i][j]++;
    if (mt < MX) mt++;
  endtask

  task automatic do_reset(input logic [15:0] s);
    rst_n = 0; seed = s;
    repeat (2) @(negedge clk);
    chk(!vec_valid && !found && found_vec == 0, "R1", {vec_valid, found}, 0);
    rst_n = 1;
    ml = (s == 0) ? 16'hACE1 : s;
    model_clear();
  endtask

  // Serve one fault: stop at the first vector equal to target, or force a hit after lim vectors
  task automatic run_fault(input logic [NB-1:0] target, input int lim, input int salt);
    logic [NB-1:0] ev, held;
    bit hit;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      while (!vec_valid) @(negedge clk);
      model_gen(ev);
      chk(vec == ev, tag, vec, ev);
      held = vec;
      if (((k + salt) % 3) == 1) begin
        // stray verdict before acceptance must be ignored (R7)
        verdict_valid = 1; verdict_hit = 1;
        @(negedge clk);
        verdict_valid = 0; verdict_hit = 0;
        chk(vec_valid && vec == held && !found, "R7", vec, held);
      end
      if (((k + salt) % 4) == 2) begin
        repeat (2) @(negedge clk);
        chk(vec_valid && vec == held, "R7", vec, held);
      end
      vec_ready = 1;
      @(negedge clk);
      vec_ready = 0;
      repeat ((k + salt) % 2) @(negedge clk);
      hit = (vec == target) || (k == lim - 1);
      verdict_valid = 1; verdict_hit = hit;
      @(negedge clk);
      verdict_valid = 0; verdict_hit = 0;
      if (hit) begin
        chk(found && found_vec == held, "R8", found_vec, held);
        @(negedge clk);
        chk(!found, "R8", found, 0);
        model_clear();
        return;
      end
      chk(!found, "R8", found, 0);
      model_miss(held);
    end
  endtask

  initial begin
    do_reset(16'h0);
    @(negedge clk);
    chk(vec_valid && vec == 5'h01, "R1", vec, 5'h01);
    do_reset(16'h0);
    run_fault(5'b11111, 80, 0);
    run_fault(5'b10110, 80, 1);
    run_fault(5'b00000, 80, 2);
    do_reset(16'h1D37);
    run_fault(5'b01101, 80, 3);
    run_fault(5'b11111, 80, 0);
    do_reset(16'hBEEF);
    run_fault(5'b11111, 300, 1);
    run_fault(5'b10001, 40, 2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule